// File: doc/BRIEF.md
# Exception Vector Priority Resolver

This block decides which pending exception the CPU takes next and tells the CPU where to find the handler address. It watches a boot request that is raised by reset, a divide-by-zero trap, a watchdog trap, and fifteen maskable peripheral interrupts in five groups. It ranks the requests, turns the winner into a two-byte vector address in the low 256 bytes of program space, and, once the CPU acknowledges, walks that vector's low byte and then its high byte as two fetch addresses.

Two arbitration steps set the order. The first step compares priority levels. The boot request and the two traps sit above every level software can program. Each peripheral group gets a 2-bit level from software, where 0 means off, and the group is eligible only when its level is above the CPU's current mask. The second step breaks ties between equal levels with a fixed source order. A software interrupt, whose vector comes straight from the instruction operand, skips arbitration. The block also reports whether the CPU must save its flags and program counter before it branches. That save is required for every exception except the boot vector.

Top module: `exc_vec_arb`

## Requirements
- R1: After reset is released, the first request offered is the boot vector at 000000H. Its fetch reads 000000H and then 000001H with `ctx_save_o` low. During reset, `req_o` and `fetch_vld_o` are low.
- R2: A `div0_i` pulse gives vector 000002H and a `wdt_i` pulse gives 000004H. Both are taken whatever the group levels and `cpu_mask_i` are, and both rank above every maskable source. The divide trap wins over the watchdog.
- R3: Maskable line `irq_i[k]` is source index n = k+3 and has vector address 2·n. Its level is read from `grp_lvl_i`: bits [1:0] for n=3..4, [3:2] for n=5..7, [5:4] for n=8..10, [7:6] for n=11..13, and [9:8] for n=14..17.
- R4: Among eligible maskable sources, the one with the higher level wins, whatever its place in the fixed order.
- R5: Among sources with equal level, the lower source index wins.
- R6: A maskable source whose level is 0, or whose level is not greater than `cpu_mask_i`, is not offered. It stays pending and is offered once the mask or level allows it.
- R7: Several pulses on one source before its acknowledge merge into one pending request. After that request is serviced, no further request is offered for that source.
- R8: When `swi_req_i` is high with an even `swi_vec_i` in 26H..FEH, the offered vector equals `swi_vec_i`. This overrides every hardware source except a pending boot request. An odd operand or an operand below 26H is ignored.
- R9: When `ack_i` is high while `req_o` is high, `fetch_vld_o` is high for exactly two cycles. It shows the even vector address first and that address plus one second. A higher-priority request that arrives meanwhile does not change either address.
- R10: `ctx_save_o` is high while a non-boot exception is offered or fetched, and low for the boot vector.
- R11: Vector address 000024H is never offered, including when it is given as a software operand.
- R12: A request pulse sampled on one clock edge appears on `req_o` after the following edge. There is no change on `req_o` after the first edge alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; sets the boot request |
| div0_i | input | 1 | Divide-by-zero trap pulse |
| wdt_i | input | 1 | Watchdog non-maskable trap pulse |
| irq_i | input | 15 | Maskable interrupt pulses, bit k is source k+3 |
| grp_lvl_i | input | 10 | Five 2-bit group priority levels, 0 = off |
| cpu_mask_i | input | 2 | Current CPU interrupt mask level |
| swi_req_i | input | 1 | Software interrupt request, held until acknowledged |
| swi_vec_i | input | 8 | Software interrupt vector operand |
| ack_i | input | 1 | CPU accepts the offered exception |
| req_o | output | 1 | An exception is offered |
| vec_addr_o | output | 24 | Vector address of the offered exception |
| fetch_vld_o | output | 1 | Vector fetch in progress |
| fetch_addr_o | output | 24 | Byte address to read during the fetch |
| ctx_save_o | output | 1 | CPU must push flags and program counter |

## Verification
A pending flag stuck or cleared wrongly appears on `vec_addr_o` at the next idle cycle: a source is served twice, never served, or served in the wrong order. A comparison error in the level or tie logic shows up two edges after the offending pulse as the wrong vector. The frozen-winner register is checked by raising a trap during a fetch. If the freeze is broken, the second fetch byte jumps to another vector in the very next cycle. A wrong save flag shows up on `ctx_save_o` as soon as the boot vector or a trap is offered.

// File: rtl/exc_vec_pkg.sv
// Shared constants and types for the exception vector resolver.
// Assumes source index 0 is the boot request, 1..2 the traps, and the
// rest are maskable lines grouped as described in grp_of().
package exc_vec_pkg;
    localparam int N_NMI  = 3;
    localparam int N_IRQ  = 15;
    localparam int N_SRC  = N_NMI + N_IRQ;
    localparam int N_GRP  = 5;
    localparam int LVL_W  = 2;
    localparam int KEY_W  = LVL_W + 1;
    localparam int IDX_W  = $clog2(N_SRC);
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 24;
    localparam logic [VEC_W-1:0] SWI_MIN = 8'h26;

    typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} fetch_st_e;

    typedef struct packed {
        logic             vld;
        logic             swi;
        logic             ctx;
        logic [IDX_W-1:0] idx;
        logic [VEC_W-1:0] vec;
    } win_t;

    // Map a maskable source index to its level group.
    function automatic int grp_of(int src);
        if (src <= 4)       return 0;
        else if (src <= 7)  return 1;
        else if (src <= 10) return 2;
        else if (src <= 13) return 3;
        else                return 4;
    endfunction
endpackage

// File: rtl/exc_vec_pend.sv
// Pending-request flags. A set pulse latches a flag and a clear removes it.
// When both hit the same flag in one cycle, the set wins, so a fresh event
// is not lost. Reset leaves only the boot request (bit 0) pending.
module exc_vec_pend
    import exc_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] pend_q;

    // Merge new events into the flags and drop the acknowledged ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= N_SRC'(1);
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R7

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & ~clr_i)) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i))); // R6
endmodule

// File: rtl/exc_vec_pick.sv
// Combinational two-step arbiter. Traps rank above every level. Maskable
// sources count only when their group level exceeds the CPU mask. Ties go
// to the lowest index. A valid software operand overrides the result unless
// the boot request is pending.
module exc_vec_pick
    import exc_vec_pkg::*;
(
    input  logic [N_SRC-1:0]       pend_i,
    input  logic [N_GRP*LVL_W-1:0] grp_lvl_i,
    input  logic [LVL_W-1:0]       mask_i,
    input  logic                   swi_req_i,
    input  logic [VEC_W-1:0]       swi_vec_i,
    output win_t                   win_o
);
    logic [KEY_W-1:0] key, best_key;
    logic [LVL_W-1:0] lvl;
    logic [IDX_W-1:0] best_idx;
    logic             found;
    logic             swi_ok;

    // Scan from the lowest rank upward so that equal keys favour lower indices.
    always_comb begin
        best_key = '0;
        best_idx = '0;
        found    = 1'b0;
        key      = '0;
        lvl      = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (i < N_NMI) begin
                key = KEY_W'(1) << LVL_W;
            end else begin
                lvl = grp_lvl_i[grp_of(i)*LVL_W +: LVL_W];
                key = (lvl > mask_i) ? {1'b0, lvl} : '0;
            end
            if (pend_i[i] && key != '0 && key >= best_key) begin
                best_key = key;
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    // Qualify the software operand: it must be even, at or above the floor, and no boot request pending.
    assign swi_ok = swi_req_i && !swi_vec_i[0] && (swi_vec_i >= SWI_MIN) && !pend_i[0];

    // Pack the result; only a boot winner skips the context save.
    always_comb begin
        win_o.vld = found || swi_ok;
        win_o.swi = swi_ok;
        win_o.ctx = swi_ok || (best_idx != '0);
        win_o.idx = swi_ok ? '0 : best_idx;
        win_o.vec = swi_ok ? swi_vec_i : VEC_W'({best_idx, 1'b0});
    end
endmodule

// File: rtl/exc_vec_fetch.sv
// Holds the registered winner and sequences the two-byte vector fetch.
// Assumes the CPU reads one byte per cycle after acknowledge. The winner
// is frozen from the acknowledge edge until the final fetch cycle ends.
module exc_vec_fetch
    import exc_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  win_t              win_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              fetch_vld_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              ctx_save_o,
    output logic              acc_o,
    output logic              acc_swi_o,
    output logic [IDX_W-1:0]  acc_idx_o
);
    fetch_st_e st;
    win_t      win_q;
    logic      upd;
    logic      busy;

    assign acc_o = (st == ST_IDLE) && ack_i && win_q.vld;
    assign upd   = ((st == ST_IDLE) && !acc_o) || (st == ST_HI);
    assign busy  = (st != ST_IDLE);

    // Track the winner while idle and step through low byte then high byte after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            win_q <= '0;
        end else begin
            if (upd) win_q <= win_i;
            case (st)
                ST_IDLE: if (acc_o) st <= ST_LO;
                ST_LO:   st <= ST_HI;
                ST_HI:   st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_o        = (st == ST_IDLE) && win_q.vld;
    assign vec_addr_o   = ADDR_W'(win_q.vec);
    assign fetch_vld_o  = busy;
    assign fetch_addr_o = busy ? ADDR_W'({win_q.vec[VEC_W-1:1], st == ST_HI}) : '0;
    assign ctx_save_o   = (req_o || busy) && win_q.ctx;
    assign acc_swi_o    = win_q.swi;
    assign acc_idx_o    = win_q.idx;

    AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LO) |-> !fetch_addr_o[0]); // R9

    AST_HIGH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LO) |=> (st == ST_HI) && (fetch_addr_o == ($past(fetch_addr_o) | ADDR_W'(1)))); // R9

    AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (vec_addr_o != ADDR_W'(24'h24))); // R11

    AST_BOOT_NOCTX: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (vec_addr_o == '0)) |-> !ctx_save_o); // R10
endmodule

// File: rtl/exc_vec_arb.sv
// Top level of the exception vector resolver. It wires the pending flags
// to the arbiter and the arbiter to the fetch sequencer, and clears a
// hardware source's flag on the cycle its request is acknowledged.
module exc_vec_arb
    import exc_vec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   div0_i,
    input  logic                   wdt_i,
    input  logic [N_IRQ-1:0]       irq_i,
    input  logic [N_GRP*LVL_W-1:0] grp_lvl_i,
    input  logic [LVL_W-1:0]       cpu_mask_i,
    input  logic                   swi_req_i,
    input  logic [VEC_W-1:0]       swi_vec_i,
    input  logic                   ack_i,
    output logic                   req_o,
    output logic [ADDR_W-1:0]      vec_addr_o,
    output logic                   fetch_vld_o,
    output logic [ADDR_W-1:0]      fetch_addr_o,
    output logic                   ctx_save_o
);
    logic [N_SRC-1:0] set_v, clr_v, pend_v;
    win_t             win;
    logic             acc, acc_swi;
    logic [IDX_W-1:0] acc_idx;

    assign set_v = {irq_i, wdt_i, div0_i, 1'b0};
    assign clr_v = (acc && !acc_swi) ? (N_SRC'(1) << acc_idx) : '0;

    exc_vec_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .pend_o (pend_v)
    );

    exc_vec_pick u_pick (
        .pend_i    (pend_v),
        .grp_lvl_i (grp_lvl_i),
        .mask_i    (cpu_mask_i),
        .swi_req_i (swi_req_i),
        .swi_vec_i (swi_vec_i),
        .win_o     (win)
    );

    exc_vec_fetch u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_i        (ack_i),
        .win_i        (win),
        .req_o        (req_o),
        .vec_addr_o   (vec_addr_o),
        .fetch_vld_o  (fetch_vld_o),
        .fetch_addr_o (fetch_addr_o),
        .ctx_save_o   (ctx_save_o),
        .acc_o        (acc),
        .acc_swi_o    (acc_swi),
        .acc_idx_o    (acc_idx)
    );

    AST_MASK_RESPECT: assert property (@(posedge clk) disable iff (!rst_n)
        (win.vld && !win.swi && (int'(win.idx) >= N_NMI)) |->
        (grp_lvl_i[grp_of(int'(win.idx))*LVL_W +: LVL_W] > cpu_mask_i)); // R6

    AST_SWI_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (win.vld && win.swi) |-> (!win.vec[0] && (win.vec >= SWI_MIN) && !pend_v[0])); // R8
endmodule

// File: tb/exc_vec_arb_bench.sv
`timescale 1ns/1ps
module exc_vec_arb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div0_i = 1'b0, wdt_i = 1'b0;
    logic [14:0] irq_i = '0;
    logic [9:0]  grp_lvl_i = '0;
    logic [1:0]  cpu_mask_i = '0;
    logic        swi_req_i = 1'b0;
    logic [7:0]  swi_vec_i = '0;
    logic        ack_i = 1'b0;
    logic        req_o, fetch_vld_o, ctx_save_o;
    logic [23:0] vec_addr_o, fetch_addr_o;
    int n_chk = 0, n_err = 0, cyc = 0;

    always #5 clk = ~clk;

    exc_vec_arb u_exc_vec_arb (.*);

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Pulse the given maskable lines and traps for one cycle.
    task automatic pulse(input logic [14:0] irq, input logic d0, input logic wd);
        irq_i = irq; div0_i = d0; wdt_i = wd;
        step();
        irq_i = '0; div0_i = 1'b0; wdt_i = 1'b0;
    endtask

    // Expect an offer of vector v, acknowledge it and check both fetch bytes.
    task automatic ack_fetch(input string tag, input logic [7:0] v, input logic ctx);
        chk({tag, " offer"}, {req_o, vec_addr_o}, {1'b1, 16'h0, v});
        chk("R11 not reserved", 32'(vec_addr_o == 24'h24), 32'h0);
        ack_i = 1'b1; swi_req_i = 1'b0;
        step();
        ack_i = 1'b0;
        chk({tag, " R9 low byte"}, {fetch_vld_o, fetch_addr_o}, {1'b1, 16'h0, v});
        chk({tag, " R10 ctx"}, 32'(ctx_save_o), 32'(ctx));
        step();
        chk({tag, " R9 high byte"}, {fetch_vld_o, fetch_addr_o}, {1'b1, 16'h0, v | 8'h1});
        step();
        chk({tag, " R9 fetch done"}, 32'(fetch_vld_o), 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 reset req", 32'(req_o), 32'h0);
        chk("R1 reset fetch", 32'(fetch_vld_o), 32'h0);
        rst_n = 1'b1;
        step();
        chk("R10 boot no ctx offer", 32'(ctx_save_o), 32'h0);
        ack_fetch("R1 boot", 8'h00, 1'b0);
        chk("R1 idle after boot", 32'(req_o), 32'h0);
    endtask

    task automatic t_levels();
        grp_lvl_i = 10'b11_00_00_00_01;
        pulse(15'h4001, 1'b0, 1'b0);
        chk("R12 not yet", 32'(req_o), 32'h0);
        step();
        ack_fetch("R4 higher level", 8'h22, 1'b1);
        ack_fetch("R3 timer1", 8'h06, 1'b1);
    endtask

    task automatic t_ties();
        grp_lvl_i = 10'b10_10_10_10_10;
        pulse(15'h00E4, 1'b0, 1'b0);
        step();
        ack_fetch("R5 tie a", 8'h0A, 1'b1);
        ack_fetch("R5 tie b", 8'h10, 1'b1);
        ack_fetch("R5 tie c", 8'h12, 1'b1);
        ack_fetch("R5 tie d", 8'h14, 1'b1);
    endtask

    task automatic t_mask();
        grp_lvl_i = 10'b00_10_00_00_00;
        cpu_mask_i = 2'd2;
        pulse(15'h0100, 1'b0, 1'b0);
        step();
        chk("R6 masked", 32'(req_o), 32'h0);
        cpu_mask_i = 2'd1;
        step();
        ack_fetch("R6 unmasked", 8'h16, 1'b1);
        cpu_mask_i = 2'd0;
        grp_lvl_i = '0;
        pulse(15'h0800, 1'b0, 1'b0);
        step();
        chk("R6 level zero", 32'(req_o), 32'h0);
        grp_lvl_i = 10'b01_00_00_00_00;
        step();
        ack_fetch("R6 enabled", 8'h1C, 1'b1);
    endtask

    task automatic t_traps();
        grp_lvl_i = 10'h3FF;
        cpu_mask_i = 2'd3;
        pulse(15'h0001, 1'b1, 1'b1);
        step();
        ack_fetch("R2 div0", 8'h02, 1'b1);
        ack_fetch("R2 watchdog", 8'h04, 1'b1);
        chk("R6 blocked by mask", 32'(req_o), 32'h0);
        cpu_mask_i = 2'd0;
        step();
        ack_fetch("R2 maskable after", 8'h06, 1'b1);
    endtask

    task automatic t_merge();
        grp_lvl_i = 10'b00_00_00_00_01;
        pulse(15'h0002, 1'b0, 1'b0);
        pulse(15'h0002, 1'b0, 1'b0);
        pulse(15'h0002, 1'b0, 1'b0);
        step();
        ack_fetch("R7 merged", 8'h08, 1'b1);
        chk("R7 served once", 32'(req_o), 32'h0);
    endtask

    task automatic t_swi();
        swi_req_i = 1'b1; swi_vec_i = 8'h40;
        pulse('0, 1'b0, 1'b1);
        step();
        chk("R10 swi ctx offer", 32'(ctx_save_o), 32'h1);
        ack_fetch("R8 swi over trap", 8'h40, 1'b1);
        ack_fetch("R8 trap after swi", 8'h04, 1'b1);
        swi_req_i = 1'b1; swi_vec_i = 8'h41;
        step(); step();
        chk("R8 odd ignored", 32'(req_o), 32'h0);
        swi_vec_i = 8'h24;
        step(); step();
        chk("R11 reserved ignored", 32'(req_o), 32'h0);
        swi_vec_i = 8'h20;
        step(); step();
        chk("R8 low ignored", 32'(req_o), 32'h0);
        swi_vec_i = 8'hFE;
        step(); step();
        ack_fetch("R8 top", 8'hFE, 1'b1);
    endtask

    task automatic t_hold();
        grp_lvl_i = 10'b00_00_00_00_01;
        pulse(15'h0001, 1'b0, 1'b0);
        step();
        chk("R9 offer", vec_addr_o, 24'h06);
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        chk("R9 held low", {fetch_vld_o, fetch_addr_o}, {1'b1, 24'h06});
        div0_i = 1'b1;
        step();
        div0_i = 1'b0;
        chk("R9 held high", {fetch_vld_o, fetch_addr_o}, {1'b1, 24'h07});
        step();
        ack_fetch("R2 late trap", 8'h02, 1'b1);
    endtask

    initial begin
        t_reset();
        t_levels();
        t_ties();
        t_mask();
        t_traps();
        t_merge();
        t_swi();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule